// File: doc/BRIEF.md
# Two-level pin multiplexer controller

This block holds the pad-function settings of a chip as registers and turns them into steering indices for every pad. There are two register banks, one for each level of the selection. A level-1 word sets a pad's function directly, or it hands the choice over to the matching level-2 word. The level-1 word also carries the pad's pull and drive-strength settings. The level-2 bank also holds two source-select words for the two management-data (MDIO) channels. Each of these words picks floating or one of seven internal peripherals for its channel.

Both banks are write-protected. A bank accepts configuration writes only after its protect register has been written with a key. The key is that register's own bus address with bit 0 set. Writing the bare address locks the bank again. Software reaches everything through a simple valid/ready register bus, and each request gets a one-cycle response that carries read data and an error flag.

Top module: `pinmux2_ctrl`

## Requirements
- R1: After reset, both banks are locked, every pad word and MDIO select reads zero, and all pad_sel, pad_pull, pad_drive and mdio_src outputs are zero.
- R2: Bank offsets are as follows: pad word i is at base+4*i for i below NUM_PADS, and the protect register is at base+0x400. In the level-2 bank only, MDIO channel 0 is at base+0x404 and channel 1 at base+0x408. Any other address, including a misaligned one, answers with resp_err=1 and resp_rdata=0, and a write to it changes nothing.
- R3: A bank unlocks when its protect register is written with bits [31:1] equal to bits [31:1] of (base+0x400) and bit 0 = 1. The same key with bit 0 = 0 locks it. The other bank is not affected.
- R4: A protect write whose bits [31:1] do not match the key leaves the lock state as it was, and it answers with resp_err=0.
- R5: A write to a pad word or MDIO select of a locked bank is dropped and answers with resp_err=1. In an unlocked bank the write is stored and answers with resp_err=0.
- R6: A read is never blocked by the lock. A pad word read returns the stored 32-bit word. A protect read returns the unlocked state in bit 0 (1 = unlocked) and zeros elsewhere. A read changes no state.
- R7: bus_ready is always 1. Every accepted request gets exactly one resp_valid pulse in the next cycle, and resp_valid is low otherwise. State changes only at a write's acceptance edge.
- R8: When a pad's level-1 function code (bits [3:0]) is 0 to 9, that pad's pad_sel equals the code.
- R9: When the level-1 code is 0xF, pad_sel is 10 plus the pad's level-2 word if that word is at most 61. If the word is larger, pad_sel is 10, the high-impedance index.
- R10: Level-1 codes 10 to 14 give pad_sel = 10 (high-impedance).
- R11: pad_pull equals level-1 bits [9:8] (0 none, 1 up, 3 down) and pad_drive equals bits [11:10] (0..3 for 4/6/8/12 mA), whatever the function code.
- R12: Each MDIO select stores only the low 3 bits of the written word (0 = floating, 1..7 = peripherals). A read returns those bits, and mdio_src[3*c +: 3] outputs them for channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Request present |
| bus_ready | output | 1 | Request accepted (always 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response for the request of the previous cycle |
| resp_err | output | 1 | Unmapped address or write to a locked bank |
| resp_rdata | output | 32 | Read data (zero for writes and errors) |
| pad_sel | output | NUM_PADS*SEL_W | Per-pad function index, pad i at [i*SEL_W +: SEL_W] |
| pad_pull | output | NUM_PADS*2 | Per-pad pull setting |
| pad_drive | output | NUM_PADS*2 | Per-pad drive-strength code |
| mdio_src | output | 6 | Source index of each MDIO channel, channel c at [3*c +: 3] |

## Verification
The assertions assume that reset is held for at least one clock edge before the first request. They also assume that bus_valid is never X outside reset, because the response-timing and state-stability properties sample bus_valid and bus_write every cycle. The bench drives every request on a falling edge and holds it for exactly one cycle. It drops bus_valid between requests and keeps all inputs at known values from time zero, so these assumptions always hold.

// File: rtl/pinmux2_ctrl.sv
module pinmux2_ctrl #(
  parameter int          NUM_PADS = 170,
  parameter int          SEL_W    = 7,
  parameter logic [31:0] L1_BASE  = 32'h0001_0000,
  parameter logic [31:0] L2_BASE  = 32'h0001_1000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_valid,
  output logic                      bus_ready,
  input  logic                      bus_write,
  input  logic [31:0]               bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic                      resp_valid,
  output logic                      resp_err,
  output logic [31:0]               resp_rdata,
  output logic [NUM_PADS*SEL_W-1:0] pad_sel,
  output logic [NUM_PADS*2-1:0]     pad_pull,
  output logic [NUM_PADS*2-1:0]     pad_drive,
  output logic [5:0]                mdio_src
);

  localparam int          IDX_W    = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;
  localparam logic [11:0] PAD_END  = 12'(NUM_PADS * 4);
  localparam logic [11:0] PROT_OFF = 12'h400;
  localparam logic [11:0] MD0_OFF  = 12'h404;
  localparam logic [11:0] MD1_OFF  = 12'h408;
  localparam logic [31:0] KEY1     = L1_BASE + 32'h400;
  localparam logic [31:0] KEY2     = L2_BASE + 32'h400;
  localparam logic [SEL_W-1:0] HIZ_SEL = SEL_W'(10);

  logic [31:0] l1_mem [NUM_PADS];
  logic [31:0] l2_mem [NUM_PADS];
  logic [2:0]  md [2];
  logic [1:0]  unl;

  logic [11:0]      off;
  logic             in1, in2, is_pad, is_prot, is_md0, is_md1, key1_ok, key2_ok;
  logic [IDX_W-1:0] pidx;

  assign bus_ready = 1'b1;
  assign off     = bus_addr[11:0];
  assign in1     = bus_addr[31:12] == L1_BASE[31:12];
  assign in2     = bus_addr[31:12] == L2_BASE[31:12];
  assign is_pad  = (off[1:0] == 2'b00) && (off < PAD_END);
  assign is_prot = off == PROT_OFF;
  assign is_md0  = in2 && off == MD0_OFF;
  assign is_md1  = in2 && off == MD1_OFF;
  assign pidx    = off[IDX_W+1:2];
  assign key1_ok = bus_wdata[31:1] == KEY1[31:1];
  assign key2_ok = bus_wdata[31:1] == KEY2[31:1];

  logic        a_err;
  logic [31:0] a_rdata;
  logic        we_p1, we_p2, we_m0, we_m1, we_k1, we_k2;

  always_comb begin
    a_err   = 1'b0;
    a_rdata = 32'h0;
    we_p1 = 1'b0; we_p2 = 1'b0; we_m0 = 1'b0; we_m1 = 1'b0;
    we_k1 = 1'b0; we_k2 = 1'b0;
    if (in1 && is_pad) begin
      if (bus_write) begin
        if (unl[0]) we_p1 = 1'b1;
        else        a_err = 1'b1;
      end else a_rdata = l1_mem[pidx];
    end else if (in2 && is_pad) begin
      if (bus_write) begin
        if (unl[1]) we_p2 = 1'b1;
        else        a_err = 1'b1;
      end else a_rdata = l2_mem[pidx];
    end else if (in1 && is_prot) begin
      if (bus_write) we_k1 = key1_ok;
      else           a_rdata = {31'h0, unl[0]};
    end else if (in2 && is_prot) begin
      if (bus_write) we_k2 = key2_ok;
      else           a_rdata = {31'h0, unl[1]};
    end else if (is_md0 || is_md1) begin
      if (bus_write) begin
        if (!unl[1])     a_err = 1'b1;
        else if (is_md0) we_m0 = 1'b1;
        else             we_m1 = 1'b1;
      end else a_rdata = {29'h0, is_md0 ? md[0] : md[1]};
    end else begin
      a_err = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_rdata <= 32'h0;
      unl        <= 2'b00;
      md[0]      <= 3'h0;
      md[1]      <= 3'h0;
      for (int i = 0; i < NUM_PADS; i++) begin
        l1_mem[i] <= 32'h0;
        l2_mem[i] <= 32'h0;
      end
    end else begin
      resp_valid <= bus_valid;
      if (bus_valid) begin
        resp_err   <= a_err;
        resp_rdata <= a_err ? 32'h0 : a_rdata;
        if (we_p1) l1_mem[pidx] <= bus_wdata;
        if (we_p2) l2_mem[pidx] <= bus_wdata;
        if (we_m0) md[0] <= bus_wdata[2:0];
        if (we_m1) md[1] <= bus_wdata[2:0];
        if (we_k1) unl[0] <= bus_wdata[0];
        if (we_k2) unl[1] <= bus_wdata[0];
      end else begin
        resp_err   <= 1'b0;
        resp_rdata <= 32'h0;
      end
    end
  end

  assign mdio_src = {md[1], md[0]};

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
    logic [3:0]  code;
    logic [31:0] w2;
    assign code = l1_mem[g][3:0];
    assign w2   = l2_mem[g];
    assign pad_pull[g*2 +: 2]  = l1_mem[g][9:8];
    assign pad_drive[g*2 +: 2] = l1_mem[g][11:10];
    assign pad_sel[g*SEL_W +: SEL_W] =
      (code < 4'd10)                      ? SEL_W'(code) :
      (code == 4'hF && w2 <= 32'd61)      ? SEL_W'(w2[5:0]) + HIZ_SEL :
                                            HIZ_SEL;
  end

endmodule

module pinmux2_chk #(
  parameter int NUM_PADS = 170,
  parameter int SEL_W    = 7
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_valid,
  input logic                      bus_write,
  input logic                      resp_valid,
  input logic                      resp_err,
  input logic [31:0]               resp_rdata,
  input logic [NUM_PADS*SEL_W-1:0] pad_sel,
  input logic [NUM_PADS*2-1:0]     pad_pull,
  input logic [NUM_PADS*2-1:0]     pad_drive,
  input logic [5:0]                mdio_src,
  input logic [1:0]                unl
);

  // R7
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid |=> resp_valid);

  // R7
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> !resp_valid);

  // R7
  idle_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
    !resp_valid |-> $stable({pad_sel, pad_pull, pad_drive, mdio_src, unl}));

  // R6
  read_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !$past(bus_write)) |-> $stable({pad_sel, pad_pull, pad_drive, mdio_src, unl}));

  // R2
  err_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_err) |-> resp_rdata == 32'h0);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (unl == 2'b00 && mdio_src == 6'h0 && pad_pull == '0 && pad_drive == '0 && pad_sel == '0));

endmodule

bind pinmux2_ctrl pinmux2_chk #(.NUM_PADS(NUM_PADS), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
  .pad_sel(pad_sel), .pad_pull(pad_pull), .pad_drive(pad_drive),
  .mdio_src(mdio_src), .unl(unl)
);

// File: tb/pinmux2_ctrl_tb.sv
module pinmux2_ctrl_tb;
  localparam int          NP  = 170;
  localparam int          SW  = 7;
  localparam logic [31:0] L1B = 32'h0001_0000;
  localparam logic [31:0] L2B = 32'h0001_1000;
  localparam logic [31:0] K1  = L1B + 32'h400;
  localparam logic [31:0] K2  = L2B + 32'h400;
  localparam int          NV  = 26;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_addr = 32'h0, bus_wdata = 32'h0;
  logic bus_ready, resp_valid, resp_err;
  logic [31:0] resp_rdata;
  logic [NP*SW-1:0] pad_sel;
  logic [NP*2-1:0]  pad_pull, pad_drive;
  logic [5:0]       mdio_src;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pinmux2_ctrl #(.NUM_PADS(NP), .SEL_W(SW), .L1_BASE(L1B), .L2_BASE(L2B)) u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
    .pad_sel(pad_sel), .pad_pull(pad_pull), .pad_drive(pad_drive),
    .mdio_src(mdio_src)
  );

  // {req[101:98], write[97], addr[96:65], wdata[64:33], exp_err[32], exp_rdata[31:0]}
  localparam logic [101:0] VEC [NV] = '{
    {4'd1,  1'b0, L1B,          32'h0,         1'b0, 32'h0},    // R1
    {4'd6,  1'b0, K1,           32'h0,         1'b0, 32'h0},    // R6
    {4'd5,  1'b1, L1B+32'h14,   32'h3,         1'b1, 32'h0},    // R5
    {4'd5,  1'b0, L1B+32'h14,   32'h0,         1'b0, 32'h0},    // R5
    {4'd4,  1'b1, K1,           32'h1234_5679, 1'b0, 32'h0},    // R4
    {4'd4,  1'b0, K1,           32'h0,         1'b0, 32'h0},    // R4
    {4'd3,  1'b1, K1,           K1 | 32'h1,    1'b0, 32'h0},    // R3
    {4'd3,  1'b0, K1,           32'h0,         1'b0, 32'h1},    // R3
    {4'd3,  1'b0, K2,           32'h0,         1'b0, 32'h0},    // R3
    {4'd11, 1'b1, L1B+32'h14,   32'hD07,       1'b0, 32'h0},    // R11
    {4'd6,  1'b0, L1B+32'h14,   32'h0,         1'b0, 32'hD07},  // R6
    {4'd5,  1'b1, L2B+32'h14,   32'h21,        1'b1, 32'h0},    // R5
    {4'd3,  1'b1, K2,           K2 | 32'h1,    1'b0, 32'h0},    // R3
    {4'd9,  1'b1, L2B+32'h14,   32'h21,        1'b0, 32'h0},    // R9
    {4'd9,  1'b1, L1B+32'h14,   32'h30F,       1'b0, 32'h0},    // R9
    {4'd12, 1'b1, L2B+32'h404,  32'hFE,        1'b0, 32'h0},    // R12
    {4'd12, 1'b0, L2B+32'h404,  32'h0,         1'b0, 32'h6},    // R12
    {4'd12, 1'b1, L2B+32'h408,  32'h3,         1'b0, 32'h0},    // R12
    {4'd8,  1'b1, L1B+32'h2A4,  32'h9,         1'b0, 32'h0},    // R8
    {4'd6,  1'b0, L1B+32'h2A4,  32'h0,         1'b0, 32'h9},    // R6
    {4'd2,  1'b0, L1B+32'h404,  32'h0,         1'b1, 32'h0},    // R2
    {4'd2,  1'b1, 32'h0002_0000, 32'h5,        1'b1, 32'h0},    // R2
    {4'd2,  1'b1, L1B+32'h2A8,  32'h5,         1'b1, 32'h0},    // R2
    {4'd2,  1'b1, L1B+32'h15,   32'h5,         1'b1, 32'h0},    // R2
    {4'd4,  1'b1, K2,           K1,            1'b0, 32'h0},    // R4
    {4'd4,  1'b0, K2,           32'h0,         1'b0, 32'h1}     // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic [31:0] a, input logic [31:0] d,
                    output logic e, output logic [31:0] r);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    chk("R7 resp_valid", {31'h0, resp_valid}, 32'h1);
    e = resp_err;
    r = resp_rdata;
  endtask

  function automatic logic [31:0] sel(input int p);
    return {25'h0, pad_sel[p*SW +: SW]};
  endfunction

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic e;
    logic [31:0] r;
    logic any;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset outputs
    any = 1'b0;
    for (int p = 0; p < NP; p++)
      if (pad_sel[p*SW +: SW] != '0 || pad_pull[p*2 +: 2] != 2'b0 || pad_drive[p*2 +: 2] != 2'b0) any = 1'b1;
    chk("R1 pad outputs nonzero", {31'h0, any}, 32'h0);
    chk("R1 mdio_src", {26'h0, mdio_src}, 32'h0);
    // R7 idle
    chk("R7 bus_ready", {31'h0, bus_ready}, 32'h1);
    chk("R7 idle resp_valid", {31'h0, resp_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][97], VEC[i][96:65], VEC[i][64:33], e, r);
      checks++;
      if (e !== VEC[i][32]) begin
        errors++;
        $display("FAIL R%0d vec %0d err actual=%b expected=%b", VEC[i][101:98], i, e, VEC[i][32]);
      end
      checks++;
      if (r !== VEC[i][31:0]) begin
        errors++;
        $display("FAIL R%0d vec %0d rdata actual=%h expected=%h", VEC[i][101:98], i, r, VEC[i][31:0]);
      end
    end

    chk("R9 pad5 sel", sel(5), 32'd43);
    chk("R11 pad5 pull", {30'h0, pad_pull[11:10]}, 32'd3);
    chk("R11 pad5 drive", {30'h0, pad_drive[11:10]}, 32'd0);
    chk("R8 pad169 sel", sel(169), 32'd9);
    chk("R12 mdio ch0", {29'h0, mdio_src[2:0]}, 32'd6);
    chk("R12 mdio ch1", {29'h0, mdio_src[5:3]}, 32'd3);

    op(1'b1, L2B+32'h14, 32'd61, e, r);
    chk("R9 level2 61", sel(5), 32'd71);
    op(1'b1, L2B+32'h14, 32'd62, e, r);
    chk("R9 level2 62 high-z", sel(5), 32'd10);
    op(1'b1, L1B+32'h14, 32'hC, e, r);
    chk("R10 code 12 high-z", sel(5), 32'd10);
    op(1'b1, L1B+32'h14, 32'hE04, e, r);
    chk("R8 code 4", sel(5), 32'd4);
    chk("R11 pull field", {30'h0, pad_pull[11:10]}, 32'd2);
    chk("R11 drive field", {30'h0, pad_drive[11:10]}, 32'd3);

    op(1'b1, K1, K1, e, r);
    chk("R3 relock err", {31'h0, e}, 32'h0);
    op(1'b0, K1, 32'h0, e, r);
    chk("R3 relocked", r, 32'h0);
    op(1'b1, L1B+32'h14, 32'h0, e, r);
    chk("R5 locked write err", {31'h0, e}, 32'h1);
    chk("R5 locked write dropped", sel(5), 32'd4);
    op(1'b0, K2, 32'h0, e, r);
    chk("R3 other bank still open", r, 32'h1);

    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pad5 after reset", sel(5), 32'd0);
    chk("R1 mdio after reset", {26'h0, mdio_src}, 32'h0);
    op(1'b0, K2, 32'h0, e, r);
    chk("R1 bank2 locked after reset", r, 32'h0);
    op(1'b0, L2B+32'h14, 32'h0, e, r);
    chk("R1 level2 word cleared", r, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule